// File: doc/BRIEF.md
# Miss Tracking File with Request Merging

This block keeps the list of cache misses that are waiting for memory. It has two separate pools. A data pool of six entries holds load misses. An instruction pool of four entries holds instruction-fetch misses. When a miss arrives, the block first compares it with the entries already held in its pool. If a pending entry covers the same block, the miss joins that entry and no second memory request goes out. If no entry covers it, the block takes the lowest-numbered free entry and queues a fill request. If no entry covers it and the pool has no free entry, the block asks the requester to replay.

Each data entry holds a block address and a bitmap of the load requesters waiting on it. A requester is known by a 3-bit tag and carries a destination register. Each tag is reused only after its wake-up has been seen. When memory returns a fill, the fill names the pool, the entry number and the block. The matching entry is freed at that clock edge, and the requesters waiting on it are reported one per cycle on a wake bus so the issue logic can restart them.

Fill requests leave in allocation order on a single request port, one per cycle. The cache arrays and the memory sit outside this block.

Top module: `mshr_miss_file`

## Requirements
- R1: After reset, fill_req_vld, wake_vld, ld_replay and if_replay are all 0 while no miss is presented.
- R2: A load miss whose block matches no valid data entry takes the lowest-numbered free data entry (numbered 0 to 5). A fill request with fill_req_instr=0, fill_req_id equal to that entry and fill_req_blk equal to the block follows in a later cycle.
- R3: A load miss whose block matches a valid data entry joins that entry. It produces no fill request and no replay, and its tag is woken when that entry's fill returns.
- R4: When all six data entries are valid, a load miss that matches none of them raises ld_replay in the same cycle and allocates nothing. A load miss that matches an entry is still merged without replay.
- R5: The instruction pool behaves the same way with four entries (numbered 0 to 3). A new block allocates the lowest free entry and requests a fill with fill_req_instr=1. A duplicate block merges without a request. A miss to a new block while all four entries are valid raises if_replay.
- R6: Fill requests leave one per cycle in allocation order. When a data entry and an instruction entry are allocated in the same cycle, the data request leaves first.
- R7: A fill return is defined by fill_rtn_instr=0 for data or 1 for instruction, together with fill_rtn_id and fill_rtn_blk. If it names a valid entry holding that block, the entry is freed at that edge. For a data entry, each waiting tag is then reported with its destination register on wake_vld/wake_tag/wake_dst, one per cycle in ascending tag order, starting the cycle after the fill.
- R8: A fill return whose block differs from the stored block, or which names a free entry, is ignored. The entry stays pending and later misses to its block still merge.
- R9: A miss whose block matches an entry whose fill returns in the same cycle is not allocated and sends no request. For a load, its tag is woken together with that fill's requesters.
- R10: The pools are independent. A full data pool does not stop instruction misses from allocating, and a full instruction pool does not stop load misses from allocating.
- R11: An entry freed by a fill is not available to a new miss in the same cycle. A non-matching miss into a full pool replays even while another of its entries is being freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_miss_vld | input | 1 | Load miss presented this cycle |
| ld_miss_blk | input | BLK_W | Block address of the load miss |
| ld_miss_tag | input | TAG_W | Requester tag of the load |
| ld_miss_dst | input | DST_W | Destination register of the load |
| ld_replay | output | 1 | Load miss refused, data pool full |
| if_miss_vld | input | 1 | Instruction-fetch miss presented this cycle |
| if_miss_blk | input | BLK_W | Block address of the fetch miss |
| if_replay | output | 1 | Fetch miss refused, instruction pool full |
| fill_req_vld | output | 1 | Fill request valid |
| fill_req_instr | output | 1 | Request is for the instruction pool |
| fill_req_id | output | ID_W | Entry number that owns the request |
| fill_req_blk | output | BLK_W | Block address to fetch |
| fill_rtn_vld | input | 1 | Fill data returning |
| fill_rtn_instr | input | 1 | Returning fill belongs to the instruction pool |
| fill_rtn_id | input | ID_W | Entry number of the returning fill |
| fill_rtn_blk | input | BLK_W | Block address of the returning fill |
| wake_vld | output | 1 | A waiting load requester is released |
| wake_tag | output | TAG_W | Tag of the released requester |
| wake_dst | output | DST_W | Destination register of the released requester |

## Verification
Two functions can coincide in one cycle: a fill that frees an entry, and a new miss that either matches that entry or needs a free slot. The bench drives a fill return and a load miss in the same cycle. In one case the load names the block being filled; the bench then expects no request and expects the load's tag in the wake sequence right after the fill's own requesters. In the other case the pool is full and the load names a new block; the bench then expects a replay in that cycle and a successful allocation of the freed entry one cycle later. A data allocation and an instruction allocation in the same cycle are also provoked, and the order of the two requests on the shared port is checked.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  // pool selector used on the request and return ports
  typedef enum logic {
    POOL_DATA  = 1'b0,
    POOL_INSTR = 1'b1
  } pool_e;

  localparam int DEF_BLK_W = 26;
  localparam int DEF_D_ENT = 6;
  localparam int DEF_I_ENT = 4;
  localparam int DEF_TAG_W = 3;
  localparam int DEF_DST_W = 5;

endpackage

// File: rtl/mshr_pool.sv
module mshr_pool #(
  parameter int N     = 6,
  parameter int BW    = 26,
  parameter int TAGS  = 8,
  parameter int IW    = 3,
  parameter bit TRACK = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [BW-1:0]   req_blk,
  input  logic [TAGS-1:0] req_bit,
  input  logic            fill_vld,
  input  logic [IW-1:0]   fill_id,
  input  logic [BW-1:0]   fill_blk,
  output logic            alloc_fire,
  output logic [IW-1:0]   alloc_id,
  output logic            replay,
  output logic            fill_ok,
  output logic [TAGS-1:0] fill_map,
  output logic [N-1:0]    occ
);

  logic [N-1:0]  vld_q, vld_d;
  logic [BW-1:0] blk_q [N];
  logic [N-1:0]  match, fill_sel, alloc_sel, merge_sel;
  logic          any_match, have_free, on_fill;

  // compare the incoming miss and the returning fill against every entry
  always_comb begin
    for (int i = 0; i < N; i++) begin
      match[i]    = req_vld && vld_q[i] && (blk_q[i] == req_blk);
      fill_sel[i] = fill_vld && (fill_id == IW'(i)) && vld_q[i] && (blk_q[i] == fill_blk);
    end
    any_match = |match;
    fill_ok   = |fill_sel;
    on_fill   = |(match & fill_sel);
    have_free = ~&vld_q;
  end

  // lowest-numbered free entry, judged on the state before this edge
  always_comb begin
    alloc_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) alloc_id = IW'(i);
    end
  end

  assign alloc_fire = req_vld && !any_match && have_free;
  assign replay     = req_vld && !any_match && !have_free;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      alloc_sel[i] = alloc_fire && (alloc_id == IW'(i));
      merge_sel[i] = match[i] && !fill_sel[i];
    end
    vld_d = (vld_q & ~fill_sel) | alloc_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (alloc_sel[i]) blk_q[i] <= req_blk;
    end
  end

  assign occ = vld_q;

  generate
    if (TRACK) begin : g_map
      logic [TAGS-1:0] map_q [N];
      logic [TAGS-1:0] map_d [N];
      logic [N-1:0]    map_en;

      always_comb begin
        fill_map = '0;
        for (int i = 0; i < N; i++) begin
          map_en[i] = alloc_sel[i] | merge_sel[i];
          map_d[i]  = alloc_sel[i] ? req_bit : (map_q[i] | req_bit);
          if (fill_sel[i]) fill_map = fill_map | map_q[i];
        end
        // a miss that lands on the returning block rides on this fill
        if (on_fill) fill_map = fill_map | req_bit;
      end

      always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
          if (map_en[i]) map_q[i] <= map_d[i];
        end
      end
    end else begin : g_nomap
      logic unused_req_bit;
      assign unused_req_bit = ^req_bit;
      assign fill_map       = '0;
    end
  endgenerate

endmodule

// File: rtl/mshr_fill_order.sv
module mshr_fill_order #(
  parameter int DEPTH = 10,
  parameter int BW    = 26,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_push,
  input  logic [IW-1:0] a_id,
  input  logic [BW-1:0] a_blk,
  input  logic          b_push,
  input  logic [IW-1:0] b_id,
  input  logic [BW-1:0] b_blk,
  output logic          out_vld,
  output logic          out_instr,
  output logic [IW-1:0] out_id,
  output logic [BW-1:0] out_blk
);

  localparam int EW = 1 + IW + BW;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem_q [DEPTH];
  logic [EW-1:0] wdata [DEPTH];
  logic [DEPTH-1:0] we;
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d, wr_nx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop   = (cnt_q != '0);
  assign wr_nx = bump(wr_q);

  // the data pool's entry is written ahead of the instruction pool's
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      we[i]    = 1'b0;
      wdata[i] = '0;
      if (a_push && (wr_q == PW'(i))) begin
        we[i]    = 1'b1;
        wdata[i] = {1'b0, a_id, a_blk};
      end
      if (b_push && ((a_push ? wr_nx : wr_q) == PW'(i))) begin
        we[i]    = 1'b1;
        wdata[i] = {1'b1, b_id, b_blk};
      end
    end
    if (a_push && b_push)     wr_d = bump(wr_nx);
    else if (a_push || b_push) wr_d = wr_nx;
    else                      wr_d = wr_q;
    rd_d  = pop ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(a_push) + CW'(b_push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i]) mem_q[i] <= wdata[i];
    end
  end

  assign out_vld = pop;
  assign {out_instr, out_id, out_blk} = mem_q[rd_q];

endmodule

// File: rtl/mshr_wake.sv
module mshr_wake #(
  parameter int TW = 3,
  parameter int DW = 5,
  parameter int TAGS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAGS-1:0] add_map,
  input  logic            wr_en,
  input  logic [TW-1:0]   wr_tag,
  input  logic [DW-1:0]   wr_dst,
  output logic            wake_vld,
  output logic [TW-1:0]   wake_tag,
  output logic [DW-1:0]   wake_dst
);

  logic [TAGS-1:0] pend_q, pend_d, low;
  logic [DW-1:0]   dst_q [TAGS];

  // release the lowest waiting tag each cycle
  always_comb begin
    low      = pend_q & (~pend_q + TAGS'(1));
    pend_d   = (pend_q & ~low) | add_map;
    wake_tag = '0;
    for (int i = 0; i < TAGS; i++) begin
      if (low[i]) wake_tag = TW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) dst_q[wr_tag] <= wr_dst;
  end

  assign wake_vld = |pend_q;
  assign wake_dst = dst_q[wake_tag];

endmodule

// File: rtl/mshr_miss_file.sv
module mshr_miss_file
  import mshr_pkg::*;
#(
  parameter int BLK_W = DEF_BLK_W,
  parameter int D_ENT = DEF_D_ENT,
  parameter int I_ENT = DEF_I_ENT,
  parameter int TAG_W = DEF_TAG_W,
  parameter int DST_W = DEF_DST_W,
  localparam int MAX_ENT = (D_ENT > I_ENT) ? D_ENT : I_ENT,
  localparam int ID_W    = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_miss_vld,
  input  logic [BLK_W-1:0] ld_miss_blk,
  input  logic [TAG_W-1:0] ld_miss_tag,
  input  logic [DST_W-1:0] ld_miss_dst,
  output logic             ld_replay,
  input  logic             if_miss_vld,
  input  logic [BLK_W-1:0] if_miss_blk,
  output logic             if_replay,
  output logic             fill_req_vld,
  output logic             fill_req_instr,
  output logic [ID_W-1:0]  fill_req_id,
  output logic [BLK_W-1:0] fill_req_blk,
  input  logic             fill_rtn_vld,
  input  logic             fill_rtn_instr,
  input  logic [ID_W-1:0]  fill_rtn_id,
  input  logic [BLK_W-1:0] fill_rtn_blk,
  output logic             wake_vld,
  output logic [TAG_W-1:0] wake_tag,
  output logic [DST_W-1:0] wake_dst
);

  localparam int TAGS        = 1 << TAG_W;
  localparam int ORDER_DEPTH = D_ENT + I_ENT;

  // asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [TAGS-1:0] ld_bit;
  logic            d_fill_vld, i_fill_vld;
  logic            d_alloc, i_alloc, d_fill_ok, i_fill_ok;
  logic [ID_W-1:0] d_alloc_id, i_alloc_id;
  logic [TAGS-1:0] d_map, unused_i_map;
  logic [D_ENT-1:0] d_occ;
  logic [I_ENT-1:0] i_occ;

  assign ld_bit     = TAGS'(1) << ld_miss_tag;
  assign d_fill_vld = fill_rtn_vld && (fill_rtn_instr == POOL_DATA);
  assign i_fill_vld = fill_rtn_vld && (fill_rtn_instr == POOL_INSTR);

  mshr_pool #(
    .N(D_ENT), .BW(BLK_W), .TAGS(TAGS), .IW(ID_W), .TRACK(1'b1)
  ) u_dpool (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_vld    (ld_miss_vld),
    .req_blk    (ld_miss_blk),
    .req_bit    (ld_bit),
    .fill_vld   (d_fill_vld),
    .fill_id    (fill_rtn_id),
    .fill_blk   (fill_rtn_blk),
    .alloc_fire (d_alloc),
    .alloc_id   (d_alloc_id),
    .replay     (ld_replay),
    .fill_ok    (d_fill_ok),
    .fill_map   (d_map),
    .occ        (d_occ)
  );

  mshr_pool #(
    .N(I_ENT), .BW(BLK_W), .TAGS(TAGS), .IW(ID_W), .TRACK(1'b0)
  ) u_ipool (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_vld    (if_miss_vld),
    .req_blk    (if_miss_blk),
    .req_bit    ('0),
    .fill_vld   (i_fill_vld),
    .fill_id    (fill_rtn_id),
    .fill_blk   (fill_rtn_blk),
    .alloc_fire (i_alloc),
    .alloc_id   (i_alloc_id),
    .replay     (if_replay),
    .fill_ok    (i_fill_ok),
    .fill_map   (unused_i_map),
    .occ        (i_occ)
  );

  mshr_fill_order #(
    .DEPTH(ORDER_DEPTH), .BW(BLK_W), .IW(ID_W)
  ) u_order (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .a_push    (d_alloc),
    .a_id      (d_alloc_id),
    .a_blk     (ld_miss_blk),
    .b_push    (i_alloc),
    .b_id      (i_alloc_id),
    .b_blk     (if_miss_blk),
    .out_vld   (fill_req_vld),
    .out_instr (fill_req_instr),
    .out_id    (fill_req_id),
    .out_blk   (fill_req_blk)
  );

  mshr_wake #(
    .TW(TAG_W), .DW(DST_W), .TAGS(TAGS)
  ) u_wake (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .add_map  (d_map),
    .wr_en    (ld_miss_vld && !ld_replay),
    .wr_tag   (ld_miss_tag),
    .wr_dst   (ld_miss_dst),
    .wake_vld (wake_vld),
    .wake_tag (wake_tag),
    .wake_dst (wake_dst)
  );

endmodule

// File: rtl/mshr_chk.sv
module mshr_chk #(
  parameter int D_ENT = 6,
  parameter int I_ENT = 4,
  parameter int TAGS  = 8
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             d_alloc,
  input logic             i_alloc,
  input logic             d_fill_ok,
  input logic             i_fill_ok,
  input logic [TAGS-1:0]  d_map,
  input logic [D_ENT-1:0] d_occ,
  input logic [I_ENT-1:0] i_occ,
  input logic             ld_replay,
  input logic             if_replay,
  input logic             fill_req_vld,
  input logic             wake_vld
);

  assert_req_after_alloc_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (d_alloc || i_alloc) |=> fill_req_vld);

  assert_wake_after_fill_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (|d_map) |=> wake_vld);

  assert_ld_replay_full_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    ld_replay |-> (&d_occ));

  assert_if_replay_full_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    if_replay |-> (&i_occ));

  assert_data_free_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (d_fill_ok && !d_alloc) |=> ($countones(d_occ) == $past($countones(d_occ)) - 1));

  assert_instr_free_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (i_fill_ok && !i_alloc) |=> ($countones(i_occ) == $past($countones(i_occ)) - 1));

  assert_no_freed_reuse_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (d_fill_ok && ld_replay) |=> !(&d_occ));

endmodule

bind mshr_miss_file mshr_chk #(
  .D_ENT(D_ENT), .I_ENT(I_ENT), .TAGS(TAGS)
) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .d_alloc      (d_alloc),
  .i_alloc      (i_alloc),
  .d_fill_ok    (d_fill_ok),
  .i_fill_ok    (i_fill_ok),
  .d_map        (d_map),
  .d_occ        (d_occ),
  .i_occ        (i_occ),
  .ld_replay    (ld_replay),
  .if_replay    (if_replay),
  .fill_req_vld (fill_req_vld),
  .wake_vld     (wake_vld)
);

// File: tb/sim_mshr_miss_file.sv
module sim_mshr_miss_file;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 26;
  localparam int TW = 3;
  localparam int DW = 5;
  localparam int IW = 3;

  logic          clk, rst_n;
  logic          ld_miss_vld;
  logic [BW-1:0] ld_miss_blk;
  logic [TW-1:0] ld_miss_tag;
  logic [DW-1:0] ld_miss_dst;
  logic          ld_replay;
  logic          if_miss_vld;
  logic [BW-1:0] if_miss_blk;
  logic          if_replay;
  logic          fill_req_vld, fill_req_instr;
  logic [IW-1:0] fill_req_id;
  logic [BW-1:0] fill_req_blk;
  logic          fill_rtn_vld, fill_rtn_instr;
  logic [IW-1:0] fill_rtn_id;
  logic [BW-1:0] fill_rtn_blk;
  logic          wake_vld;
  logic [TW-1:0] wake_tag;
  logic [DW-1:0] wake_dst;

  int checks = 0;
  int errors = 0;

  logic [1+IW+BW-1:0] exp_req_q [$];
  logic [TW+DW-1:0]   exp_wake_q [$];

  bit    ld_chk, if_chk, ld_exp, if_exp;
  string ld_lbl, if_lbl;

  mshr_miss_file u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_miss_vld(ld_miss_vld), .ld_miss_blk(ld_miss_blk), .ld_miss_tag(ld_miss_tag),
    .ld_miss_dst(ld_miss_dst), .ld_replay(ld_replay),
    .if_miss_vld(if_miss_vld), .if_miss_blk(if_miss_blk), .if_replay(if_replay),
    .fill_req_vld(fill_req_vld), .fill_req_instr(fill_req_instr),
    .fill_req_id(fill_req_id), .fill_req_blk(fill_req_blk),
    .fill_rtn_vld(fill_rtn_vld), .fill_rtn_instr(fill_rtn_instr),
    .fill_rtn_id(fill_rtn_id), .fill_rtn_blk(fill_rtn_blk),
    .wake_vld(wake_vld), .wake_tag(wake_tag), .wake_dst(wake_dst)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    ld_miss_vld = 0; ld_miss_blk = '0; ld_miss_tag = '0; ld_miss_dst = '0;
    if_miss_vld = 0; if_miss_blk = '0;
    fill_rtn_vld = 0; fill_rtn_instr = 0; fill_rtn_id = '0; fill_rtn_blk = '0;
    ld_chk = 0; if_chk = 0;
  endtask

  // load miss; id >= 0 means a data fill request is expected for that entry
  task automatic ld(input logic [BW-1:0] b, input int tag, input int dst,
                    input bit rep, input int id, input string lbl);
    ld_miss_vld = 1; ld_miss_blk = b; ld_miss_tag = TW'(tag); ld_miss_dst = DW'(dst);
    ld_chk = 1; ld_exp = rep; ld_lbl = lbl;
    if (id >= 0) exp_req_q.push_back({1'b0, IW'(id), b});
  endtask

  task automatic ifm(input logic [BW-1:0] b, input bit rep, input int id, input string lbl);
    if_miss_vld = 1; if_miss_blk = b;
    if_chk = 1; if_exp = rep; if_lbl = lbl;
    if (id >= 0) exp_req_q.push_back({1'b1, IW'(id), b});
  endtask

  task automatic fill(input bit instr, input int id, input logic [BW-1:0] b);
    fill_rtn_vld = 1; fill_rtn_instr = instr; fill_rtn_id = IW'(id); fill_rtn_blk = b;
  endtask

  task automatic expw(input int tag, input int dst);
    exp_wake_q.push_back({TW'(tag), DW'(dst)});
  endtask

  task automatic tick();
    #2;
    if (ld_chk) check(ld_lbl, "ld_replay", ld_replay, ld_exp);
    if (if_chk) check(if_lbl, "if_replay", if_replay, if_exp);
    @(negedge clk);
    clear_inputs();
  endtask

  // monitor: scoreboard pops one expected item per observed output
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && fill_req_vld) begin
        if (exp_req_q.size() == 0) begin
          check("R6", "unexpected fill request", {fill_req_instr, fill_req_id, fill_req_blk}, 0);
        end else begin
          check("R6", "fill request {instr,id,blk}",
                {fill_req_instr, fill_req_id, fill_req_blk}, exp_req_q.pop_front());
        end
      end
      if (rst_n && wake_vld) begin
        if (exp_wake_q.size() == 0) begin
          check("R7", "unexpected wake", {wake_tag, wake_dst}, 0);
        end else begin
          check("R7", "wake {tag,dst}", {wake_tag, wake_dst}, exp_wake_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [BW-1:0] BA = 26'h00A0, BB = 26'h00B0, BC = 26'h00C0, BD = 26'h00D0;
  localparam logic [BW-1:0] BX = 26'h1000, BY = 26'h1100, BZ = 26'h1200, BWW = 26'h1300;

  initial begin
    rst_n = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: quiet after reset
    check("R1", "fill_req_vld", fill_req_vld, 0);
    check("R1", "wake_vld", wake_vld, 0);
    check("R1", "ld_replay", ld_replay, 0);
    check("R1", "if_replay", if_replay, 0);

    // R2: allocation from the lowest free entry
    ld(BA, 1, 7, 0, 0, "R2"); tick();
    ld(BB, 2, 8, 0, 1, "R2"); tick();
    // R3: same block merges, no request
    ld(BA, 3, 9, 0, -1, "R3"); tick();
    // R7: fill frees entry 0 and wakes tags 1 then 3
    expw(1, 7); expw(3, 9);
    fill(0, 0, BA); tick();
    repeat (3) tick();
    // R2: entry 0 is reused first
    ld(BC, 1, 10, 0, 0, "R2"); tick();

    // R8: wrong block, then a free entry: both ignored
    fill(0, 1, BD); tick();
    fill(0, 2, BB); tick();
    ld(BB, 4, 11, 0, -1, "R8"); tick();
    expw(2, 8); expw(4, 11);
    fill(0, 1, BB); tick();
    repeat (3) tick();

    // R9: miss on a block whose fill returns in the same cycle
    ld(BD, 5, 12, 0, 1, "R2"); tick();
    expw(5, 12); expw(6, 13);
    fill(0, 1, BD); ld(BD, 6, 13, 0, -1, "R9"); tick();
    repeat (3) tick();

    // R4: fill the data pool (entry 0 holds BC)
    for (int k = 0; k < 5; k++) begin
      ld(26'h2000 + 26'(k), k + 2, k + 18, 0, k + 1, "R4"); tick();
    end
    ld(26'h3000, 7, 23, 1, -1, "R4"); tick();
    ld(26'h2002, 7, 23, 0, -1, "R4"); tick();
    // R10: instruction miss allocates while the data pool is full
    ifm(BX, 0, 0, "R10"); tick();

    // R11: entry 2 freed this cycle, new block still replays
    expw(3, 19);
    fill(0, 2, 26'h2001); ld(26'h3000, 0, 2, 1, -1, "R11"); tick();
    ld(26'h3000, 0, 2, 0, 2, "R11"); tick();
    repeat (2) tick();

    // free entry 5, then fill the instruction pool
    expw(6, 22);
    fill(0, 5, 26'h2004); tick();
    repeat (2) tick();
    ifm(BY, 0, 1, "R5"); tick();
    ifm(BZ, 0, 2, "R5"); tick();
    ifm(BWW, 0, 3, "R5"); tick();
    // R5 and R10: instruction pool full while a load still allocates
    ifm(26'h1400, 1, -1, "R5"); ld(26'h3100, 6, 3, 0, 5, "R10"); tick();
    ifm(BY, 0, -1, "R5"); tick();

    // R6: simultaneous allocations, data request first
    fill(1, 1, BY); tick();
    expw(5, 21);
    fill(0, 4, 26'h2003); tick();
    repeat (2) tick();
    ld(26'h3200, 5, 4, 0, 4, "R6"); ifm(26'h1500, 0, 1, "R6"); tick();
    repeat (6) tick();

    check("R6", "requests left in queue", exp_req_q.size(), 0);
    check("R7", "wakes left in queue", exp_wake_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule